// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

The block moves 8-bit characters over a three-wire synchronous link: a shift clock, a serial output and a serial input. Transmit and receive share one shift clock, so a character can be sent and another received in the same eight clock periods. Software sees a small register-style port. A transmit buffer with an empty flag is loaded by a write strobe. A receive buffer comes with a full flag and a sticky overrun flag. Separate enables control the transmit and receive directions. A 2-bit clock configuration selects where the shift clock comes from.

With the internal clock, a divider derives the shift clock from the system clock and the block drives the clock pin. The clock idles high. It runs only while a character is in flight. With receive enabled, it runs continuously until receive is disabled. With the external clock, the pin is an input that is resynchronized to the system clock, and the block follows the edges it sees.

The controller has three named states. IDLE holds the clock high. LOW is the low half of a bit. HIGH is the high half of a bit. The transitions are:
- start: IDLE to LOW on a falling event when there is work.
- sample: LOW to HIGH on a rising event.
- next-bit: HIGH to LOW on a falling event within a character.
- chain: HIGH to LOW on a falling event after bit 7 when there is work, which starts a new character.
- stop: HIGH to IDLE after bit 7 when there is no work.

There is work when the transmit side is enabled with a byte waiting, or when the receive side is enabled.

Top module: `sync_serial_port`

## Requirements
- R1: A character is exactly 8 data bits on `sdo`, least significant bit first, with no parity or extra bit.
- R2: With the internal clock, `sdo` changes only in the cycle in which `sck_o` falls, so it is stable at the following rise.
- R3: The receiver samples `sdi` at each rising shift-clock event, least significant bit first. After the eighth sample the byte appears on `rx_data` and `rx_full` is set.
- R4: After the last bit of a character, `sdo` keeps the level of that bit until the next character starts.
- R5: With the internal clock, each character produces exactly 8 low pulses on `sck_o`, and `sck_o` is high whenever no character is in flight.
- R6: If a transmit byte is waiting when a character ends, the next character follows with no extra idle time, so every falling edge is exactly two half-periods after the previous one.
- R7: With the internal clock and `rx_en` set, the shift clock keeps running with no transmit data. It stops once `rx_en` is cleared and the current character ends.
- R8: If a character completes while `rx_full` is set, `rx_ovr` is set, the new byte is discarded, and `rx_data` keeps the earlier byte. `rx_ovr` stays set until an `ovr_clr` pulse.
- R9: An `rx_rd` pulse clears `rx_full`.
- R10: A `tx_wr` pulse stores `tx_wdata` and clears `tx_empty`. `tx_empty` is set again when that byte is moved into the shifter at the start of a character.
- R11: While `tx_en` is low, a waiting transmit byte starts no transfer and stays in the buffer.
- R12: `clk_cfg[1]`=0 selects the internal clock, with `sck_oe`=1. `clk_cfg[1]`=1 selects the external clock on `sck_i`, with `sck_oe`=0. In external mode `sck_i` passes through a two-flop synchronizer. `sdo` moves after each detected fall and `sdi` is sampled after each detected rise.
- R13: After reset, `tx_empty`=1, `rx_full`=0, `rx_ovr`=0, `sck_o`=1 and `sdo`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_cfg | input | 2 | Clock configuration; bit 1 selects the external clock |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_wdata | input | 8 | Byte to transmit |
| tx_empty | output | 1 | Transmit buffer is empty |
| rx_rd | input | 1 | Read strobe; clears the receive full flag |
| ovr_clr | input | 1 | Clears the overrun flag |
| rx_data | output | 8 | Last accepted received byte |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| rx_ovr | output | 1 | Overrun flag |
| sck_i | input | 1 | External shift clock |
| sck_o | output | 1 | Internally generated shift clock |
| sck_oe | output | 1 | Output enable for the clock pin |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |

## Verification
Transmit-only runs use bytes with different last bits, such as 0x5A and 0x81. These distinguish bit order from a line that returns to idle after the last bit. A pair of chained bytes measures the spacing between every falling edge, which separates gapless chaining from a restart through the idle state. Receive-only runs leave two bytes unread, which shows whether the clock runs on freely, whether the overrun keeps the old byte, and whether the flag is sticky. Full-duplex bytes and an externally clocked exchange show that both directions share one bit timing in each clock mode, and that a byte held back by a low transmit enable is neither sent nor lost.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    localparam int CHAR_BITS = 8;
    localparam int IDX_W     = $clog2(CHAR_BITS);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } ssp_state_t;
endpackage

// File: rtl/ssp_clk_unit.sv
module ssp_clk_unit #(
    parameter int HALF_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_sel,
    input  logic run,
    input  logic in_low,
    input  logic sck_in,
    output logic fall_ev,
    output logic rise_ev
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DW-1:0] LAST_CNT = DW'(HALF_DIV - 1);

    logic [DW-1:0] div_q;
    logic tick;
    logic [SYNC_STAGES:0] sync_q;
    logic ext_fall, ext_rise;

    assign tick = run && !ext_sel && (div_q == LAST_CNT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          div_q <= '0;
        else if (!run || ext_sel || tick)    div_q <= '0;
        else                                 div_q <= div_q + 1'b1;
    end

    // synchronizer stages plus one history stage for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-1:0], sck_in};
    end

    assign ext_fall = sync_q[SYNC_STAGES]   && !sync_q[SYNC_STAGES-1];
    assign ext_rise = !sync_q[SYNC_STAGES]  &&  sync_q[SYNC_STAGES-1];

    assign fall_ev = ext_sel ? ext_fall : (tick && !in_low);
    assign rise_ev = ext_sel ? ext_rise : (tick &&  in_low);
endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
    import ssp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             fall_ev,
    input  logic             rise_ev,
    output ssp_state_t       state,
    output logic [IDX_W-1:0] bit_idx,
    output logic             start_char,
    output logic             next_bit,
    output logic             sample,
    output logic             char_done
);
    ssp_state_t state_n;
    logic last;

    assign last = (bit_idx == IDX_W'(CHAR_BITS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (fall_ev && go) state_n = ST_LOW;
            ST_LOW:  if (rise_ev)       state_n = ST_HIGH;
            ST_HIGH: begin
                if (last && !go)        state_n = ST_IDLE;
                else if (fall_ev)       state_n = ST_LOW;
            end
            default:                    state_n = ST_IDLE;
        endcase
    end

    always_comb begin
        start_char = 1'b0;
        next_bit   = 1'b0;
        sample     = 1'b0;
        char_done  = 1'b0;
        unique case (state)
            ST_IDLE: start_char = fall_ev && go;
            ST_LOW: begin
                sample    = rise_ev;
                char_done = rise_ev && last;
            end
            ST_HIGH: begin
                start_char = fall_ev && last && go;
                next_bit   = fall_ev && !last;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          bit_idx <= '0;
        else if (start_char) bit_idx <= '0;
        else if (next_bit)   bit_idx <= bit_idx + 1'b1;
    end
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
    import ssp_pkg::*;
#(
    parameter int HALF_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           clk_cfg,
    input  logic                 tx_en,
    input  logic                 rx_en,
    input  logic                 tx_wr,
    input  logic [CHAR_BITS-1:0] tx_wdata,
    output logic                 tx_empty,
    input  logic                 rx_rd,
    input  logic                 ovr_clr,
    output logic [CHAR_BITS-1:0] rx_data,
    output logic                 rx_full,
    output logic                 rx_ovr,
    input  logic                 sck_i,
    output logic                 sck_o,
    output logic                 sck_oe,
    input  logic                 sdi,
    output logic                 sdo
);
    ssp_state_t state;
    logic [IDX_W-1:0] bit_idx;
    logic start_char, next_bit, sample, char_done;
    logic fall_ev, rise_ev, go, run, ext_sel;
    logic [CHAR_BITS-1:0] tx_buf, tx_sh, rx_sh, rx_byte;
    logic tx_active;

    assign ext_sel = clk_cfg[1];
    assign go      = (tx_en && !tx_empty) || rx_en;
    assign run     = (state != ST_IDLE) || go;
    assign sck_oe  = !ext_sel;
    assign sck_o   = ext_sel ? 1'b1 : (state != ST_LOW);
    assign rx_byte = {sdi, rx_sh[CHAR_BITS-1:1]};

    ssp_clk_unit #(.HALF_DIV(HALF_DIV), .SYNC_STAGES(SYNC_STAGES)) u_clk (
        .clk(clk), .rst_n(rst_n), .ext_sel(ext_sel), .run(run),
        .in_low(state == ST_LOW), .sck_in(sck_i),
        .fall_ev(fall_ev), .rise_ev(rise_ev)
    );

    ssp_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .go(go), .fall_ev(fall_ev), .rise_ev(rise_ev),
        .state(state), .bit_idx(bit_idx), .start_char(start_char),
        .next_bit(next_bit), .sample(sample), .char_done(char_done)
    );

    // transmit buffer and shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_buf    <= '0;
            tx_empty  <= 1'b1;
            tx_sh     <= '0;
            tx_active <= 1'b0;
            sdo       <= 1'b1;
        end else begin
            if (start_char) begin
                if (tx_en && !tx_empty) begin
                    tx_sh     <= tx_buf;
                    sdo       <= tx_buf[0];
                    tx_empty  <= 1'b1;
                    tx_active <= 1'b1;
                end else begin
                    tx_active <= 1'b0;
                end
            end else if (next_bit && tx_active) begin
                sdo   <= tx_sh[1];
                tx_sh <= tx_sh >> 1;
            end
            if (tx_wr) begin
                tx_buf   <= tx_wdata;
                tx_empty <= 1'b0;
            end
        end
    end

    // receive shifter and buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh   <= '0;
            rx_data <= '0;
            rx_full <= 1'b0;
            rx_ovr  <= 1'b0;
        end else begin
            if (rx_rd)   rx_full <= 1'b0;
            if (ovr_clr) rx_ovr  <= 1'b0;
            if (sample)  rx_sh   <= rx_byte;
            if (char_done && rx_en) begin
                if (rx_full) begin
                    rx_ovr <= 1'b1;
                end else begin
                    rx_data <= rx_byte;
                    rx_full <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_wr,
    input logic       tx_empty,
    input logic       sck_o,
    input logic       sck_oe,
    input logic       sdo,
    input logic [7:0] rx_data,
    input logic       rx_ovr,
    input logic       ovr_clr
);
    AST_SDO_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_oe && $past(sck_oe) && (sdo != $past(sdo))) |-> ($past(sck_o) && !sck_o)); // R2

    AST_EMPTY_CLEARS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_empty) |-> $past(tx_wr)); // R10

    AST_OVERRUN_KEEPS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ovr) |-> $stable(rx_data)); // R8

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ovr && !ovr_clr) |=> rx_ovr); // R8
endmodule

bind sync_serial_port ssp_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_empty(tx_empty),
    .sck_o(sck_o), .sck_oe(sck_oe), .sdo(sdo), .rx_data(rx_data),
    .rx_ovr(rx_ovr), .ovr_clr(ovr_clr)
);

// File: tb/sync_serial_port_test.sv
module sync_serial_port_test;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] clk_cfg = 2'b00;
    logic tx_en = 1'b0, rx_en = 1'b0, tx_wr = 1'b0, rx_rd = 1'b0, ovr_clr = 1'b0;
    logic [7:0] tx_wdata = '0;
    logic sck_i = 1'b1, sdi = 1'b0;
    logic tx_empty, rx_full, rx_ovr, sck_o, sck_oe, sdo;
    logic [7:0] rx_data;

    int nchecks = 0, nerrs = 0, cyc = 0, quiet = 0;
    logic prev_sck = 1'b1, prev_sdo = 1'b1;
    bit tx_seen[$];
    bit rx_src[$];
    int falls[$];

    always #4 clk = ~clk;

    sync_serial_port #(.HALF_DIV(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .clk_cfg(clk_cfg), .tx_en(tx_en), .rx_en(rx_en),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_empty(tx_empty), .rx_rd(rx_rd),
        .ovr_clr(ovr_clr), .rx_data(rx_data), .rx_full(rx_full), .rx_ovr(rx_ovr),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .sdi(sdi), .sdo(sdo)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (!ok) begin
            nerrs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] seen_byte(input int off);
        logic [7:0] b = '0;
        for (int i = 0; i < 8; i++) if (off + i < tx_seen.size()) b[i] = tx_seen[off + i];
        return b;
    endfunction

    task automatic push_rx(input logic [7:0] b);
        for (int i = 0; i < 8; i++) rx_src.push_back(b[i]);
    endtask

    task automatic clear_obs();
        tx_seen.delete(); falls.delete(); rx_src.delete();
    endtask

    task automatic write_tx(input logic [7:0] b);
        @(negedge clk); tx_wr = 1'b1; tx_wdata = b;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (10) @(negedge clk);
        while (quiet < 20) @(negedge clk);
    endtask

    // per-clock reference observer for the internal clock
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (sck_o != prev_sck) quiet = 0; else quiet++;
            chk(sck_oe == !clk_cfg[1], "R12 sck_oe", sck_oe, !clk_cfg[1]);
            if (!clk_cfg[1]) begin
                if (sdo != prev_sdo)
                    chk(prev_sck && !sck_o, "R2 sdo moved without sck fall", sck_o, 0);
                if (prev_sck && !sck_o) begin
                    falls.push_back(cyc);
                    if (rx_src.size() > 0) sdi = rx_src.pop_front(); else sdi = 1'b0;
                end
                if (!prev_sck && sck_o) tx_seen.push_back(sdo);
            end
            prev_sck = sck_o;
            prev_sdo = sdo;
        end
    end

    always @(negedge clk) begin
        if (cyc > 150000) begin
            nerrs++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
            $finish;
        end
    end

    initial begin
        int n0;
        logic [7:0] cap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk(tx_empty == 1'b1, "R13 tx_empty", tx_empty, 1);
        chk(rx_full == 1'b0, "R13 rx_full", rx_full, 0);
        chk(rx_ovr == 1'b0, "R13 rx_ovr", rx_ovr, 0);
        chk(sck_o == 1'b1 && sdo == 1'b1, "R13 sck/sdo", {sck_o, sdo}, 2'b11);

        // single byte, MSB 0
        clear_obs();
        tx_en = 1'b1;
        write_tx(8'h5A);
        chk(tx_empty == 1'b0, "R10 empty after write", tx_empty, 0);
        wait_idle();
        chk(seen_byte(0) == 8'h5A, "R1 lsb-first byte", seen_byte(0), 8'h5A);
        chk(falls.size() == 8, "R5 eight pulses", falls.size(), 8);
        chk(tx_seen.size() == 8, "R1 eight bits", tx_seen.size(), 8);
        chk(sdo == 1'b0, "R4 sdo holds msb", sdo, 0);
        chk(sck_o == 1'b1, "R5 sck high when idle", sck_o, 1);
        chk(tx_empty == 1'b1, "R10 empty after load", tx_empty, 1);

        // tx disabled: byte waits
        clear_obs();
        tx_en = 1'b0;
        write_tx(8'h81);
        repeat (60) @(negedge clk);
        chk(falls.size() == 0, "R11 no clock while tx_en low", falls.size(), 0);
        chk(tx_empty == 1'b0, "R11 byte kept", tx_empty, 0);
        tx_en = 1'b1;
        wait_idle();
        chk(seen_byte(0) == 8'h81, "R11 byte sent after enable", seen_byte(0), 8'h81);
        chk(sdo == 1'b1, "R4 sdo holds msb 1", sdo, 1);

        // back-to-back
        clear_obs();
        write_tx(8'h3C);
        for (int k = 0; k < 200 && !tx_empty; k++) @(negedge clk);
        write_tx(8'hC3);
        wait_idle();
        chk(falls.size() == 16, "R6 sixteen pulses", falls.size(), 16);
        chk({seen_byte(8), seen_byte(0)} == 16'hC33C, "R6 chained bytes",
            {seen_byte(8), seen_byte(0)}, 16'hC33C);
        begin
            int bad = 0;
            for (int i = 1; i < falls.size(); i++) if (falls[i] - falls[i-1] != 2*HALF) bad++;
            chk(bad == 0, "R6 gapless fall spacing", bad, 0);
        end

        // receive-only with overrun
        tx_en = 1'b0;
        clear_obs();
        push_rx(8'h5A); push_rx(8'h77);
        rx_en = 1'b1;
        for (int k = 0; k < 400 && !rx_full; k++) @(negedge clk);
        chk(rx_full == 1'b1, "R3 full after char", rx_full, 1);
        chk(rx_data == 8'h5A, "R3 received byte", rx_data, 8'h5A);
        for (int k = 0; k < 400 && !rx_ovr; k++) @(negedge clk);
        chk(rx_ovr == 1'b1, "R8 overrun set", rx_ovr, 1);
        chk(rx_data == 8'h5A, "R8 old byte kept", rx_data, 8'h5A);
        n0 = falls.size();
        repeat (40) @(negedge clk);
        chk(falls.size() > n0, "R7 clock keeps running", falls.size(), n0 + 1);
        rx_en = 1'b0;
        wait_idle();
        n0 = falls.size();
        repeat (60) @(negedge clk);
        chk(falls.size() == n0 && sck_o == 1'b1, "R7 clock stops after rx_en low", falls.size(), n0);
        @(negedge clk); rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
        chk(rx_full == 1'b0, "R9 read clears full", rx_full, 0);
        chk(rx_ovr == 1'b1, "R8 overrun sticky", rx_ovr, 1);
        @(negedge clk); ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
        chk(rx_ovr == 1'b0, "R8 overrun cleared", rx_ovr, 0);

        // full duplex, internal clock
        clear_obs();
        push_rx(8'h2B);
        tx_en = 1'b1;
        write_tx(8'hE1);
        rx_en = 1'b1;
        for (int k = 0; k < 400 && !rx_full; k++) @(negedge clk);
        rx_en = 1'b0;
        chk(rx_data == 8'h2B, "R3 duplex receive", rx_data, 8'h2B);
        wait_idle();
        chk(seen_byte(0) == 8'hE1, "R1 duplex transmit", seen_byte(0), 8'hE1);
        chk(rx_ovr == 1'b0, "R8 no overrun in duplex", rx_ovr, 0);
        @(negedge clk); rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;

        // external clock
        clk_cfg = 2'b10;
        @(negedge clk);
        chk(sck_oe == 1'b0, "R12 pin is input", sck_oe, 0);
        write_tx(8'h96);
        rx_en = 1'b1;
        cap = '0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); sck_i = 1'b0; sdi = (8'h1E >> i) & 1'b1;
            repeat (8) @(negedge clk);
            cap[i] = sdo;
            sck_i = 1'b1;
            repeat (8) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        chk(cap == 8'h96, "R12 external transmit", cap, 8'h96);
        chk(rx_full == 1'b1 && rx_data == 8'h1E, "R12 external receive", rx_data, 8'h1E);
        chk(tx_empty == 1'b1, "R10 external load empties", tx_empty, 1);
        rx_en = 1'b0;
        tx_en = 1'b0;
        repeat (10) @(negedge clk);

        $display("  Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
        $finish;
    end
endmodule